// File: doc/BRIEF.md
# Burst Clock Activity Event Controller

This block is the activity gate of a mobile power-management unit. Software uses a small byte-wide register bus to program seven enable registers. Each enable bit chooses one system activity source: an interrupt line, a serial, parallel, disk or floppy channel, an audio channel, bus-hold acknowledge, ring indicate, SMI or an external event. Detectors outside this block report activity on those sources as single-cycle pulses.

One bit in register 2 is a master gate over all other enables. When that gate is open and an enabled source pulses, the block loads a burst countdown timer from a programmable reload input. It also releases the active-low stop-clock request. The request stays released while the timer counts down. When the count has run out and no new event has arrived, the request is asserted again.

Top module: `burst_event_gate`

## Requirements
- R1: After reset every enable register reads 00h and the stop-clock request `stopClkN` is low (asserted).
- R2: Register n (0 to 6) sits at bus address E4h+n. Reads of any other address return 00h, and writes to any other address change no register.
- R3: Writable bits read back as written. Reserved bits always read 0: register 0 bit 2, register 1 bit 5, register 2 bits 4 and 7, and all of register 3.
- R4: Register 2 bit 0 is the global enable. While it is 0, no activity pulse changes `stopClkN`.
- R5: Activity input bit n*8+b belongs to register n bit b. A pulse on an enabled source while the global enable is 1 makes `stopClkN` high at the next clock edge.
- R6: After the event edge, `stopClkN` stays high for `reloadVal`+1 cycles and then goes low, provided no further qualifying event arrives.
- R7: A qualifying event that arrives during a countdown reloads the timer, and a full count starts again from that edge.
- R8: Activity pulses on disabled sources, on reserved bit positions, or on the global-enable bit position are ignored.
- R9: Several qualifying pulses in the same cycle behave exactly like one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register bus address |
| regWrEn | input | 1 | Write strobe, one byte per cycle |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| actIn | input | 56 | Activity pulses, bit n*8+b for register n bit b |
| reloadVal | input | 16 | Burst timer reload value |
| stopClkN | output | 1 | Stop-clock request, low means stop |

## Verification
Faults in this block show up at two ports. A corrupted enable bit or mask is visible at `regRdData` as soon as that address is read. The same fault also shows at `stopClkN` on the first pulse from the affected source: the output either fails to rise one edge later or rises when it should not. A wrong timer load or decrement moves the falling edge of `stopClkN` by at least one cycle, so that edge is checked every cycle against a model of the countdown. The random phase mixes writes, sparse pulses and small reload values, so retriggers and zero-length bursts occur often.

// File: rtl/bce_pkg.sv
package bce_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
  } tmrCtl_t;

  localparam int GLOBAL_REG = 2;
  localparam int GLOBAL_BIT = 0;

  // writable bits of each enable register
  function automatic logic [7:0] wrMask(input int idx);
    case (idx)
      0:       wrMask = 8'hFB;
      1:       wrMask = 8'hDF;
      2:       wrMask = 8'h6F;
      3:       wrMask = 8'h00;
      default: wrMask = 8'hFF;
    endcase
  endfunction

  // bits that name an activity source (global gate excluded)
  function automatic logic [7:0] srcMask(input int idx);
    srcMask = wrMask(idx);
    if (idx == GLOBAL_REG) srcMask[GLOBAL_BIT] = 1'b0;
  endfunction
endpackage

// File: rtl/bce_datapath.sv
module bce_datapath
  import bce_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int TMR_W = 16,
  parameter logic [7:0] BASE_ADDR = 8'hE4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            regAddr,
  input  logic                  regWrEn,
  input  logic [7:0]            regWrData,
  output logic [7:0]            regRdData,
  input  logic [NUM_REGS*8-1:0] actIn,
  input  logic [TMR_W-1:0]      reloadVal,
  input  tmrCtl_t               ctl,
  output logic                  hit,
  output logic                  cntZero
);
  localparam logic [7:0] NR8 = 8'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];
  logic [7:0] offs;
  logic addrOk;
  logic [NUM_REGS-1:0] qualBits;
  logic [TMR_W-1:0] cnt;

  assign offs = regAddr - BASE_ADDR;
  assign addrOk = (regAddr >= BASE_ADDR) && (offs < NR8);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= '0;
      else if (regWrEn && addrOk && offs == 8'(i)) regs[i] <= regWrData & wrMask(i);
    end
    assign qualBits[i] = |(actIn[i*8 +: 8] & regs[i] & srcMask(i));

    // R3
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && addrOk && offs == 8'(i)) |=> regs[i] == ($past(regWrData) & wrMask(i)));
  end

  assign hit = regs[GLOBAL_REG][GLOBAL_BIT] & (|qualBits);

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addrOk && offs == 8'(i)) regRdData = regs[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.load) cnt <= reloadVal;
    else if (ctl.dec) cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  // R7
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> cnt == $past(reloadVal));
  // R6
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dec |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/bce_ctrl.sv
module bce_ctrl
  import bce_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hit,
  input  logic    cntZero,
  output tmrCtl_t ctl,
  output logic    stopClkN
);
  assign ctl.load = hit;
  assign ctl.dec  = !hit && !cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopClkN <= 1'b0;
    else if (hit) stopClkN <= 1'b1;
    else if (cntZero) stopClkN <= 1'b0;
  end

  // R5
  event_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> stopClkN);
  // R6
  expire_assert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hit && cntZero) |=> !stopClkN);
  // R4
  rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopClkN) |-> $past(hit));
endmodule

// File: rtl/burst_event_gate.sv
module burst_event_gate
  import bce_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int TMR_W = 16,
  parameter logic [7:0] BASE_ADDR = 8'hE4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            regAddr,
  input  logic                  regWrEn,
  input  logic [7:0]            regWrData,
  output logic [7:0]            regRdData,
  input  logic [NUM_REGS*8-1:0] actIn,
  input  logic [TMR_W-1:0]      reloadVal,
  output logic                  stopClkN
);
  tmrCtl_t ctl;
  logic hit;
  logic cntZero;

  bce_datapath #(.NUM_REGS(NUM_REGS), .TMR_W(TMR_W), .BASE_ADDR(BASE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .actIn(actIn),
    .reloadVal(reloadVal), .ctl(ctl), .hit(hit), .cntZero(cntZero));

  bce_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hit(hit), .cntZero(cntZero),
    .ctl(ctl), .stopClkN(stopClkN));
endmodule

// File: tb/burst_event_gate_test.sv
module burst_event_gate_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [55:0] actIn = '0;
  logic [15:0] reloadVal = '0;
  logic stopClkN;

  int total = 0;
  int bad = 0;
  logic [7:0] mRegs [7];
  int mCnt = 0;
  bit mStop = 1'b0;

  burst_event_gate uut (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .actIn(actIn),
    .reloadVal(reloadVal), .stopClkN(stopClkN));

  always #5 clk = ~clk;

  // R3 writable bits per register
  function automatic logic [7:0] bWr(input int i);
    case (i)
      0: return 8'hFB;
      1: return 8'hDF;
      2: return 8'h6F;
      3: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // R8 source bits: writable minus global gate
  function automatic logic [7:0] bSrc(input int i);
    return (i == 2) ? 8'h6E : bWr(i);
  endfunction

  function automatic logic [7:0] bRead(input logic [7:0] a);
    if (a >= 8'hE4 && a <= 8'hEA) return mRegs[a - 8'hE4];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input logic [55:0] act, input logic [15:0] rv, input string tag);
    bit h;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; actIn = act; reloadVal = rv;
    #1;
    check({tag, " read"}, 32'(regRdData), 32'(bRead(a)));
    @(posedge clk);
    h = 1'b0;
    for (int i = 0; i < 7; i++)
      if ((act[i*8 +: 8] & mRegs[i] & bSrc(i)) != 8'h00) h = 1'b1;
    h = h && mRegs[2][0];
    if (h) begin mCnt = int'(rv); mStop = 1'b1; end
    else if (mCnt != 0) mCnt--;
    else mStop = 1'b0;
    if (we && a >= 8'hE4 && a <= 8'hEA) mRegs[a - 8'hE4] = d & bWr(int'(a - 8'hE4));
    #1;
    check({tag, " stop"}, 32'(stopClkN), 32'(mStop));
  endtask

  task automatic idle(input int n, input logic [15:0] rv, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 8'hE4 + 8'(k % 7), 8'h00, '0, rv, tag);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 7; i++) mRegs[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    #1; check("R1 stop", 32'(stopClkN), 32'd0);
    for (int i = 0; i < 7; i++) step(1'b0, 8'hE4 + 8'(i), 8'h00, '0, 16'd0, "R1");
    // R3 write all ones, reserved bits read zero
    for (int i = 0; i < 7; i++) step(1'b1, 8'hE4 + 8'(i), 8'hFF, '0, 16'd0, "R3");
    for (int i = 0; i < 7; i++) step(1'b0, 8'hE4 + 8'(i), 8'h00, '0, 16'd0, "R3");
    // R2 out of range
    step(1'b1, 8'hEB, 8'h00, '0, 16'd0, "R2");
    step(1'b1, 8'hE3, 8'h00, '0, 16'd0, "R2");
    step(1'b0, 8'hEB, 8'h00, '0, 16'd0, "R2");
    step(1'b0, 8'h00, 8'h00, '0, 16'd0, "R2");
    idle(7, 16'd0, "R2");
    // R4 gate closed
    step(1'b1, 8'hE6, 8'h6E, '0, 16'd0, "R4");
    step(1'b0, 8'hE6, 8'h00, {56{1'b1}}, 16'd5, "R4");
    idle(3, 16'd5, "R4");
    // R5 and R6 single event on IRQ0
    step(1'b1, 8'hE6, 8'h6F, '0, 16'd0, "R5");
    step(1'b0, 8'hE4, 8'h00, 56'h1, 16'd3, "R5");
    idle(6, 16'd3, "R6");
    // R6 zero reload
    step(1'b0, 8'hE4, 8'h00, 56'h2, 16'd0, "R6");
    idle(3, 16'd0, "R6");
    // R7 retrigger mid countdown
    step(1'b0, 8'hE4, 8'h00, 56'h1, 16'd4, "R7");
    idle(2, 16'd4, "R7");
    step(1'b0, 8'hE9, 8'h00, 56'h1 << 40, 16'd4, "R7");
    idle(7, 16'd4, "R7");
    // R8 reserved positions and global bit position ignored
    step(1'b0, 8'hE4, 8'h00, (56'h1 << 2) | (56'h1 << 16) | (56'h1 << 13), 16'd2, "R8");
    step(1'b1, 8'hE9, 8'h00, '0, 16'd2, "R8");
    step(1'b0, 8'hE9, 8'h00, 56'hFF << 40, 16'd2, "R8");
    idle(2, 16'd2, "R8");
    // R9 simultaneous pulses
    step(1'b0, 8'hE4, 8'h00, 56'h00_0000_0000_FFFF, 16'd2, "R9");
    idle(5, 16'd2, "R9");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [55:0] a;
      bit w;
      a = '0;
      if ($urandom_range(0, 3) == 0) a[$urandom_range(0, 55)] = 1'b1;
      if ($urandom_range(0, 15) == 0) a[$urandom_range(0, 55)] = 1'b1;
      w = ($urandom_range(0, 7) == 0);
      step(w, 8'hE3 + 8'($urandom_range(0, 8)), 8'($urandom()), a,
           16'($urandom_range(0, 6)), "R6");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule